// File: doc/BRIEF.md
# Virtual processor run/stop controller

This block keeps a bitmask of the virtual processors (VPs) that are currently executing. Software starts or stops VPs by writing a bitmask to one of two write-only command registers. Only VPs whose state would actually change respond to a command.

A start command gives each newly started VP a single-cycle reset pulse, so that it begins at its reset vector. A stop command raises a halt level on each VP that is being stopped, and that level stays high until the VP is started again. A read-only status register returns the running mask.

The two command registers have their own write strobes, so both can be written in the same cycle. Bit i of every mask refers to VP i.

Top module: `vp_runstop_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `running` equals 1 (only VP 0 runs), `vp_halt` has every bit set except bit 0, and `vp_reset` is all zeros.
- R2: A start write with bit i set for a VP that is not running sets `running[i]`, clears `vp_halt[i]` and sets `vp_reset[i]`, all visible after the next rising clock edge.
- R3: A start write has no effect on a VP that is already running: no reset pulse, and no change to `running` or `vp_halt` for that VP.
- R4: A stop write with bit i set for a running VP clears `running[i]` and sets `vp_halt[i]`, visible after the next rising clock edge. `vp_halt[i]` then stays high until VP i is started again.
- R5: A stop write has no effect on a VP that is not running: `running` and `vp_halt` keep their values for that VP.
- R6: When both command registers are written in the same cycle with the same bit set, the stop wins. That VP ends up not running and halted, and it gets no reset pulse. Different bits in the two masks act independently.
- R7: Bit i of `run_data` and `stop_data` addresses VP i. Bits at positions NUM_VP and above are ignored.
- R8: A read with `rd_addr` equal to 0x10 returns the running mask in bits NUM_VP-1:0, with all higher bits zero. Reads at any other address return zero.
- R9: A reset pulse on `vp_reset[i]` lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_wr | input | 1 | Write strobe for the start command register |
| run_data | input | 64 | Start mask; bit i selects VP i |
| stop_wr | input | 1 | Write strobe for the stop command register |
| stop_data | input | 64 | Stop mask; bit i selects VP i |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 64 | Read data; status register at offset 0x10 |
| vp_reset | output | NUM_VP | Per-VP single-cycle reset pulse |
| vp_halt | output | NUM_VP | Per-VP halt request level |
| running | output | NUM_VP | Current running mask |

## Verification
A start and a stop can land in the same cycle. They may target the same VP, or different VPs, and the targeted VP may be running or stopped. The stimulus table strobes both registers together with overlapping masks, first for a stopped VP and then for a running one, and it also pairs a start of some VPs with a stop of another. After each such edge the bench compares `running`, `vp_reset` and `vp_halt` against hand-derived masks. It expects the overlapping bit to end up stopped and without a reset pulse, while the other bits follow their own command.

// File: rtl/vp_runstop_ctrl.sv
module vp_runstop_ctrl #(
  parameter int unsigned NUM_VP   = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned STAT_OFS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_wr,
  input  logic [63:0]       run_data,
  input  logic              stop_wr,
  input  logic [63:0]       stop_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data,
  output logic [NUM_VP-1:0] vp_reset,
  output logic [NUM_VP-1:0] vp_halt,
  output logic [NUM_VP-1:0] running
);
  localparam logic [NUM_VP-1:0] BOOT_MASK = NUM_VP'(1);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

  logic [NUM_VP-1:0] run_req, stop_req, start_set, stop_set;

  assign run_req   = run_wr  ? run_data[NUM_VP-1:0]  : '0;
  assign stop_req  = stop_wr ? stop_data[NUM_VP-1:0] : '0;
  assign start_set = run_req & ~running & ~stop_req;
  assign stop_set  = stop_req & running;

  generate
    if (NUM_VP < 64) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^{run_data[63:NUM_VP], stop_data[63:NUM_VP]};
    end
  endgenerate

  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        running[i]  <= BOOT_MASK[i];
        vp_halt[i]  <= ~BOOT_MASK[i];
        vp_reset[i] <= 1'b0;
      end else begin
        vp_reset[i] <= start_set[i];
        if (stop_set[i]) begin
          running[i] <= 1'b0;
          vp_halt[i] <= 1'b1;
        end else if (start_set[i]) begin
          running[i] <= 1'b1;
          vp_halt[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADDR) rd_data[NUM_VP-1:0] = running;
  end
endmodule

// File: rtl/vp_runstop_chk.sv
module vp_runstop_chk #(
  parameter int unsigned NUM_VP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_wr,
  input logic [63:0]       run_data,
  input logic              stop_wr,
  input logic [63:0]       stop_data,
  input logic [63:0]       rd_data,
  input logic [NUM_VP-1:0] vp_reset,
  input logic [NUM_VP-1:0] vp_halt,
  input logic [NUM_VP-1:0] running
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((vp_reset & $past(vp_reset)) == '0)); // R9

  AST_PULSE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((vp_reset & ~running) == '0)); // R2

  AST_HALT_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((vp_halt & running) == '0)); // R4

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && run_wr && stop_wr) |=>
      ((running & $past(run_data[NUM_VP-1:0] & stop_data[NUM_VP-1:0])) == '0)); // R6

  AST_RUN_IDEMPOTENT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && run_wr) |=> ((vp_reset & $past(running)) == '0)); // R3

  AST_STOP_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && stop_wr && !run_wr) |=> ((vp_halt & ~$past(vp_halt) & ~$past(running)) == '0)); // R5

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data >> NUM_VP) == 64'd0)); // R8
endmodule

bind vp_runstop_ctrl vp_runstop_chk #(.NUM_VP(NUM_VP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_wr(run_wr), .run_data(run_data),
  .stop_wr(stop_wr), .stop_data(stop_data), .rd_data(rd_data),
  .vp_reset(vp_reset), .vp_halt(vp_halt), .running(running)
);

// File: tb/test_vp_runstop_ctrl.sv
module test_vp_runstop_ctrl;
  localparam int NV = 8;
  localparam int NVEC = 11;
  // {run_wr, run_mask, stop_wr, stop_mask, exp_running, exp_reset, exp_halt}
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 8'h06, 1'b0, 8'h00, 8'h07, 8'h06, 8'hF8},  // R2
    {1'b1, 8'h03, 1'b0, 8'h00, 8'h07, 8'h00, 8'hF8},  // R3
    {1'b0, 8'h00, 1'b1, 8'h0C, 8'h03, 8'h00, 8'hFC},  // R4
    {1'b0, 8'h00, 1'b1, 8'h30, 8'h03, 8'h00, 8'hFC},  // R5
    {1'b1, 8'h10, 1'b1, 8'h10, 8'h03, 8'h00, 8'hFC},  // R6 stopped VP
    {1'b1, 8'h02, 1'b1, 8'h02, 8'h01, 8'h00, 8'hFE},  // R6 running VP
    {1'b1, 8'hC0, 1'b1, 8'h01, 8'hC0, 8'hC0, 8'h3F},  // R6 independent bits
    {1'b0, 8'h00, 1'b0, 8'h00, 8'hC0, 8'h00, 8'h3F},  // R9
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'hFF, 8'h3F, 8'h00},  // R2
    {1'b0, 8'h00, 1'b1, 8'hFF, 8'h00, 8'h00, 8'hFF},  // R4
    {1'b1, 8'h01, 1'b0, 8'h00, 8'h01, 8'h01, 8'hFE}   // R2
  };

  logic clk = 1'b0, rst_n = 1'b0, run_wr = 1'b0, stop_wr = 1'b0;
  logic [63:0] run_data = '0, stop_data = '0, rd_data;
  logic [7:0] rd_addr = 8'h10;
  logic [NV-1:0] vp_reset, vp_halt, running;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  vp_runstop_ctrl #(.NUM_VP(NV)) i_vp_runstop_ctrl (
    .clk(clk), .rst_n(rst_n), .run_wr(run_wr), .run_data(run_data),
    .stop_wr(stop_wr), .stop_data(stop_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .vp_reset(vp_reset), .vp_halt(vp_halt), .running(running)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [7:0] er, input logic [7:0] ep,
                           input logic [7:0] eh);
    chk({req, " running"}, 64'(running), 64'(er));
    chk({req, " reset"},   64'(vp_reset), 64'(ep));
    chk({req, " halt"},    64'(vp_halt), 64'(eh));
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R1 in reset", 8'h01, 8'h00, 8'hFE);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after reset", 8'h01, 8'h00, 8'hFE);

    for (int i = 0; i < NVEC; i++) begin
      run_wr    = VEC[i][41];
      run_data  = 64'(VEC[i][40:33]);
      stop_wr   = VEC[i][32];
      stop_data = 64'(VEC[i][31:24]);
      @(negedge clk);
      run_wr = 1'b0; stop_wr = 1'b0;
      chk_state($sformatf("vec%0d", i), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
      chk("R8 status", rd_data, 64'(VEC[i][23:16]));
    end

    // R9: pulse from last vector gone one cycle later
    @(negedge clk);
    chk_state("R9 idle", 8'h01, 8'h00, 8'hFE);

    // R7: bits above NUM_VP ignored
    run_wr = 1'b1; run_data = 64'hFFFF_FFFF_FFFF_FF00;
    @(negedge clk);
    run_wr = 1'b0;
    chk_state("R7 run upper", 8'h01, 8'h00, 8'hFE);
    stop_wr = 1'b1; stop_data = 64'hFFFF_FFFF_FFFF_FF00;
    @(negedge clk);
    stop_wr = 1'b0;
    chk_state("R7 stop upper", 8'h01, 8'h00, 8'hFE);

    // R8: other offsets read zero, status upper bits zero
    rd_addr = 8'h08; #1;
    chk("R8 other addr", rd_data, 64'd0);
    rd_addr = 8'h00; #1;
    chk("R8 addr0", rd_data, 64'd0);
    rd_addr = 8'h10; #1;
    chk("R8 status", rd_data, 64'h1);

    // R1: reset again mid-run
    run_wr = 1'b1; run_data = 64'hF0;
    @(negedge clk);
    run_wr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_state("R1 re-reset", 8'h01, 8'h00, 8'hFE);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule